// File: doc/BRIEF.md
# Calendar Time Counter with BCD/Binary Register Images

The block keeps a wall-clock calendar (seconds, minutes, hours, weekday, day of month, month and a two-digit year) and advances it by one second on each qualified 1 Hz tick. The time is held internally in binary. The host-visible register images are re-encoded at the end of each update. The encoding follows two mode inputs: packed BCD or plain binary, and 24-hour or 12-hour with a PM flag.

Each advance starts an update window of `UIP_CYCLES` clocks, during which an update-in-progress flag is high. When the window closes, the images are refreshed and a one-cycle update-done strobe is given to the neighbouring alarm and flag logic. A hold input lets the host freeze the visible images while it writes a new time, which is taken into the counter when the hold is released. Writes made without the hold take effect at once.

Top module: `rtc_calendar_core`

## Requirements
- R1: After reset the images read seconds 00, minutes 00, hours 00, weekday 01, day 01, month 01, year 00, with `busy` and `upd_done` low.
- R2: Time advances on a `tick_1hz` pulse only when `osc_ctl` equals 3'b010. With any other value the tick changes no image, does not raise `busy` and gives no `upd_done`.
- R3: Seconds and minutes wrap from 59 to 0 and hours from 23 to 0. The weekday counts 1 to 7 and wraps to 1 at the day change.
- R4: The day of month wraps to 1 after the month's length (30 days for April, June, September and November; 28 or 29 for February; 31 otherwise). The month then steps, wrapping from 12 to 1 with a year step, and the year wraps from 99 to 0.
- R5: February has 29 days when the full year `BASE_YEAR + year` is divisible by 4 and is either not divisible by 100 or divisible by 400. With the default 2000, years 00 and 24 are leap years and 23 is not.
- R6: With `bin_mode` 0 every image is packed BCD (tens in bits 7:4, units in bits 3:0). With `bin_mode` 1 every image is plain binary. Written values are decoded with the same rule.
- R7: With `hr24` 0 the hour image is 1 to 12 with bit 7 set for hours 12 to 23. Midnight reads 12 with bit 7 clear, and noon reads 12 with bit 7 set. A written 12-hour value is decoded back to the same 24-hour time.
- R8: After a qualified tick taken with `set_hold` 0, `busy` is high for exactly `UIP_CYCLES` cycles. On the edge that drops it, the images show the new time and `upd_done` is high for one cycle.
- R9: While `set_hold` is 1, `busy` stays low and images change only by host writes. `upd_done` still pulses at the end of each update.
- R10: `wr_sel` picks the field (0 seconds, 1 minutes, 2 hours, 3 weekday, 4 day, 5 month, 6 year; 7 selects nothing). A write always updates that image. It loads the counter at once when `set_hold` is 0, and when `set_hold` falls otherwise. A write with select 7 changes neither images nor time.
- R11: If a write with `set_hold` 0 and a qualified tick fall in one cycle, the written field takes the written value and the other fields advance. If the release of `set_hold` and a tick fall in one cycle, the reloaded time is advanced by one second.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tick_1hz | input | 1 | One-cycle pulse per second |
| osc_ctl | input | 3 | Oscillator control field; 3'b010 runs the clock |
| set_hold | input | 1 | Freeze images and suspend loading of host writes |
| bin_mode | input | 1 | 1 = binary images, 0 = packed BCD |
| hr24 | input | 1 | 1 = 24-hour hour image, 0 = 12-hour with PM bit 7 |
| wr_en | input | 1 | Host write strobe |
| wr_sel | input | 3 | Field select for the write |
| wr_data | input | 8 | Write value in the current encoding |
| sec_img | output | 8 | Seconds image |
| min_img | output | 8 | Minutes image |
| hour_img | output | 8 | Hours image |
| wday_img | output | 8 | Weekday image |
| mday_img | output | 8 | Day-of-month image |
| mon_img | output | 8 | Month image |
| year_img | output | 8 | Year image |
| busy | output | 1 | Update in progress |
| upd_done | output | 1 | One-cycle strobe at the end of each update |

## Verification
The counter's own one-second advance and a host load can land on the same clock edge, and the bench provokes this in two ways. In the first, a minutes write is driven in the very cycle that carries the tick. The result is judged correct only if the minutes image keeps the written value while the seconds image shows the old seconds plus one. In the second, the hold is released in the cycle that carries the tick. The result is judged correct only if the images show the time written during the hold plus exactly one second, so that neither the reload nor the tick is lost.

// File: rtl/rtc_cal_pkg.sv
package rtc_cal_pkg;

   localparam int NFIELD = 7;

   localparam logic [2:0] SEL_SEC  = 3'd0;
   localparam logic [2:0] SEL_MIN  = 3'd1;
   localparam logic [2:0] SEL_HOUR = 3'd2;
   localparam logic [2:0] SEL_WDAY = 3'd3;
   localparam logic [2:0] SEL_MDAY = 3'd4;
   localparam logic [2:0] SEL_MON  = 3'd5;
   localparam logic [2:0] SEL_YEAR = 3'd6;

   typedef struct packed {
      logic [6:0] year;
      logic [3:0] mon;
      logic [4:0] mday;
      logic [2:0] wday;
      logic [4:0] hour;
      logic [5:0] min;
      logic [5:0] sec;
   } cal_t;

   // binary value 0..99 to image byte
   function automatic logic [7:0] enc_val(input logic [6:0] v, input logic bin);
      int iv;
      iv = int'(v);
      if (bin) return {1'b0, v};
      return 8'(((iv / 10) << 4) + (iv % 10));
   endfunction

   // image byte to binary value
   function automatic logic [6:0] dec_val(input logic [7:0] b, input logic bin);
      if (bin) return b[6:0];
      return 7'(int'(b[7:4]) * 10 + int'(b[3:0]));
   endfunction

   function automatic logic [7:0] enc_hour(input logic [4:0] h, input logic bin,
                                           input logic h24);
      int ih;
      int h12;
      ih = int'(h);
      if (h24) return enc_val(7'(ih), bin);
      h12 = ((ih % 12) == 0) ? 12 : (ih % 12);
      return enc_val(7'(h12), bin) | ((ih >= 12) ? 8'h80 : 8'h00);
   endfunction

   function automatic logic [4:0] dec_hour(input logic [7:0] b, input logic bin,
                                           input logic h24);
      int v;
      if (h24) return 5'(dec_val(b, bin));
      v = int'(dec_val({1'b0, b[6:0]}, bin));
      if (v == 12) v = 0;
      if (b[7]) v = v + 12;
      return 5'(v);
   endfunction

   function automatic logic is_leap(input int y);
      return ((y % 4) == 0) && (((y % 100) != 0) || ((y % 400) == 0));
   endfunction

   function automatic logic [4:0] month_len(input logic [3:0] mon, input logic leap);
      case (mon)
         4'd2:                    return leap ? 5'd29 : 5'd28;
         4'd4, 4'd6, 4'd9, 4'd11: return 5'd30;
         default:                 return 5'd31;
      endcase
   endfunction

endpackage

// File: rtl/rtc_cal_step.sv
module rtc_cal_step
   import rtc_cal_pkg::*;
#(
   parameter int BASE_YEAR = 2000
) (
   input  cal_t cur,
   output cal_t nxt
);

   logic       leap;
   logic [4:0] dim;

   always_comb begin
      leap = is_leap(BASE_YEAR + int'(cur.year));
      dim  = month_len(cur.mon, leap);
      nxt  = cur;
      // R3: carry chain seconds -> minutes -> hours -> day
      if (cur.sec >= 6'd59) begin
         nxt.sec = '0;
         if (cur.min >= 6'd59) begin
            nxt.min = '0;
            if (cur.hour >= 5'd23) begin
               nxt.hour = '0;
               nxt.wday = (cur.wday >= 3'd7 || cur.wday == 3'd0) ? 3'd1 : cur.wday + 3'd1;
               // R4 R5: month length decides the day wrap
               if (cur.mday >= dim) begin
                  nxt.mday = 5'd1;
                  if (cur.mon >= 4'd12) begin
                     nxt.mon  = 4'd1;
                     nxt.year = (cur.year >= 7'd99) ? 7'd0 : cur.year + 7'd1;
                  end else begin
                     nxt.mon = cur.mon + 4'd1;
                  end
               end else begin
                  nxt.mday = cur.mday + 5'd1;
               end
            end else begin
               nxt.hour = cur.hour + 5'd1;
            end
         end else begin
            nxt.min = cur.min + 6'd1;
         end
      end else begin
         nxt.sec = cur.sec + 6'd1;
      end
   end

endmodule

// File: rtl/rtc_cal_encode.sv
module rtc_cal_encode
   import rtc_cal_pkg::*;
(
   input  cal_t                    tm,
   input  logic                    bin_mode,
   input  logic                    hr24,
   output logic [NFIELD-1:0][7:0]  img
);

   // R6 R7: one encoder per field, mode applied at copy time
   always_comb begin
      img[SEL_SEC]  = enc_val({1'b0, tm.sec}, bin_mode);
      img[SEL_MIN]  = enc_val({1'b0, tm.min}, bin_mode);
      img[SEL_HOUR] = enc_hour(tm.hour, bin_mode, hr24);
      img[SEL_WDAY] = enc_val({4'd0, tm.wday}, bin_mode);
      img[SEL_MDAY] = enc_val({2'd0, tm.mday}, bin_mode);
      img[SEL_MON]  = enc_val({3'd0, tm.mon}, bin_mode);
      img[SEL_YEAR] = enc_val(tm.year, bin_mode);
   end

endmodule

// File: rtl/rtc_uip_window.sv
module rtc_uip_window #(
   parameter int CYCLES = 8
) (
   input  logic clk,
   input  logic rst_n,
   input  logic start,
   input  logic set_hold,
   output logic busy,
   output logic fin
);

   logic active_q;

   generate
      if (CYCLES == 1) begin : g_single
         assign fin = active_q;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)     active_q <= 1'b0;
            else if (start) active_q <= 1'b1;
            else if (fin)   active_q <= 1'b0;
         end
      end else begin : g_count
         localparam int CW = $clog2(CYCLES);
         logic [CW-1:0] cnt_q;
         assign fin = active_q && (cnt_q == '0);
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               active_q <= 1'b0;
               cnt_q    <= '0;
            end else if (start) begin
               active_q <= 1'b1;
               cnt_q    <= CW'(CYCLES - 1);
            end else if (fin) begin
               active_q <= 1'b0;
            end else if (active_q) begin
               cnt_q <= cnt_q - 1'b1;
            end
         end
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        busy <= 1'b0;
      else if (set_hold) busy <= 1'b0;
      else if (start)    busy <= 1'b1;
      else if (fin)      busy <= 1'b0;
   end

   // R9
   busy_set_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
      set_hold |=> !busy);

   // R8
   busy_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (start && !set_hold) |=> busy);

endmodule

// File: rtl/rtc_calendar_core.sv
module rtc_calendar_core
   import rtc_cal_pkg::*;
#(
   parameter int         UIP_CYCLES = 8,
   parameter int         BASE_YEAR  = 2000,
   parameter logic [2:0] OSC_RUN    = 3'b010
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic       tick_1hz,
   input  logic [2:0] osc_ctl,
   input  logic       set_hold,
   input  logic       bin_mode,
   input  logic       hr24,
   input  logic       wr_en,
   input  logic [2:0] wr_sel,
   input  logic [7:0] wr_data,
   output logic [7:0] sec_img,
   output logic [7:0] min_img,
   output logic [7:0] hour_img,
   output logic [7:0] wday_img,
   output logic [7:0] mday_img,
   output logic [7:0] mon_img,
   output logic [7:0] year_img,
   output logic       busy,
   output logic       upd_done
);

   localparam logic [NFIELD-1:0][7:0] IMG_RST = 56'h00_01_01_01_00_00_00;

   generate
      if (UIP_CYCLES < 1) begin : g_bad_uip
         $error("UIP_CYCLES must be at least 1");
      end
      if ((BASE_YEAR % 100) != 0 || BASE_YEAR < 0) begin : g_bad_base
         $error("BASE_YEAR must be a non-negative multiple of 100");
      end
   endgenerate

   cal_t                    cur_q, base_c, step_c, nxt_c, img_tm;
   logic [NFIELD-1:0][7:0]  img_q, enc_c;
   logic                    set_q, reload, tick_ok, host_ld, fin;

   // R2: only the running oscillator code qualifies a tick
   assign tick_ok = tick_1hz && (osc_ctl == OSC_RUN);
   // R10: release of the hold takes the images as the new time
   assign reload  = set_q && !set_hold;
   assign host_ld = wr_en && !set_hold;

   always_comb begin
      img_tm.sec  = 6'(dec_val(img_q[SEL_SEC], bin_mode));
      img_tm.min  = 6'(dec_val(img_q[SEL_MIN], bin_mode));
      img_tm.hour = dec_hour(img_q[SEL_HOUR], bin_mode, hr24);
      img_tm.wday = 3'(dec_val(img_q[SEL_WDAY], bin_mode));
      img_tm.mday = 5'(dec_val(img_q[SEL_MDAY], bin_mode));
      img_tm.mon  = 4'(dec_val(img_q[SEL_MON], bin_mode));
      img_tm.year = dec_val(img_q[SEL_YEAR], bin_mode);
   end

   assign base_c = reload ? img_tm : cur_q;

   rtc_cal_step #(.BASE_YEAR(BASE_YEAR)) u_step (
      .cur (base_c),
      .nxt (step_c)
   );

   // R11: reload, then advance, then the written field overrides
   always_comb begin
      nxt_c = tick_ok ? step_c : base_c;
      if (host_ld) begin
         case (wr_sel)
            SEL_SEC:  nxt_c.sec  = 6'(dec_val(wr_data, bin_mode));
            SEL_MIN:  nxt_c.min  = 6'(dec_val(wr_data, bin_mode));
            SEL_HOUR: nxt_c.hour = dec_hour(wr_data, bin_mode, hr24);
            SEL_WDAY: nxt_c.wday = 3'(dec_val(wr_data, bin_mode));
            SEL_MDAY: nxt_c.mday = 5'(dec_val(wr_data, bin_mode));
            SEL_MON:  nxt_c.mon  = 4'(dec_val(wr_data, bin_mode));
            SEL_YEAR: nxt_c.year = dec_val(wr_data, bin_mode);
            default:  ;
         endcase
      end
   end

   rtc_cal_encode u_enc (
      .tm       (cur_q),
      .bin_mode (bin_mode),
      .hr24     (hr24),
      .img      (enc_c)
   );

   rtc_uip_window #(.CYCLES(UIP_CYCLES)) u_win (
      .clk      (clk),
      .rst_n    (rst_n),
      .start    (tick_ok),
      .set_hold (set_hold),
      .busy     (busy),
      .fin      (fin)
   );

   // R1
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q    <= '{year: 7'd0, mon: 4'd1, mday: 5'd1, wday: 3'd1,
                       hour: 5'd0, min: 6'd0, sec: 6'd0};
         img_q    <= IMG_RST;
         set_q    <= 1'b0;
         upd_done <= 1'b0;
      end else begin
         cur_q    <= nxt_c;
         set_q    <= set_hold;
         upd_done <= fin;
         // R8 R9: copy out at window end unless held
         if (fin && !set_hold) img_q <= enc_c;
         if (wr_en && wr_sel != 3'd7) img_q[wr_sel] <= wr_data;
      end
   end

   assign sec_img  = img_q[SEL_SEC];
   assign min_img  = img_q[SEL_MIN];
   assign hour_img = img_q[SEL_HOUR];
   assign wday_img = img_q[SEL_WDAY];
   assign mday_img = img_q[SEL_MDAY];
   assign mon_img  = img_q[SEL_MON];
   assign year_img = img_q[SEL_YEAR];

   // R2
   halt_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tick_1hz && osc_ctl != OSC_RUN && !host_ld && !reload) |=> $stable(cur_q));

   // R9
   image_frozen_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (set_hold && !wr_en) |=> $stable(img_q));

   // R8
   done_on_fall_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($fell(busy) && !$past(set_hold)) |-> upd_done);

endmodule

// File: tb/tb_rtc_calendar_core.sv
module tb_rtc_calendar_core;

   localparam int UIP = 8;

   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_1hz = 1'b0;
   logic [2:0] osc_ctl = 3'b010;
   logic       set_hold = 1'b0;
   logic       bin_mode = 1'b0;
   logic       hr24 = 1'b1;
   logic       wr_en = 1'b0;
   logic [2:0] wr_sel = 3'd0;
   logic [7:0] wr_data = 8'd0;
   logic [7:0] sec_img, min_img, hour_img, wday_img, mday_img, mon_img, year_img;
   logic       busy, upd_done;

   int n_chk = 0;
   int n_fail = 0;
   bit done = 0;

   always #5 clk = ~clk;

   rtc_calendar_core #(.UIP_CYCLES(UIP)) dut (
      .clk(clk), .rst_n(rst_n), .tick_1hz(tick_1hz), .osc_ctl(osc_ctl),
      .set_hold(set_hold), .bin_mode(bin_mode), .hr24(hr24),
      .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
      .sec_img(sec_img), .min_img(min_img), .hour_img(hour_img),
      .wday_img(wday_img), .mday_img(mday_img), .mon_img(mon_img),
      .year_img(year_img), .busy(busy), .upd_done(upd_done));

   task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [2:0] sel, input logic [7:0] d);
      @(negedge clk);
      wr_en = 1'b1; wr_sel = sel; wr_data = d;
      @(negedge clk);
      wr_en = 1'b0;
   endtask

   task automatic set_date(input logic [7:0] y, mo, d, w, h, mi, s);
      wr(3'd6, y); wr(3'd5, mo); wr(3'd4, d); wr(3'd3, w);
      wr(3'd2, h); wr(3'd1, mi); wr(3'd0, s);
   endtask

   task automatic tick_wait(output logic b_seen, output logic u_seen);
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
      b_seen = busy;
      u_seen = 1'b0;
      for (int i = 0; i < UIP; i++) begin
         @(negedge clk);
         u_seen = u_seen | upd_done;
         b_seen = b_seen | busy;
      end
      @(negedge clk);
   endtask

   task automatic t_reset();
      chk("R1 images", {sec_img, min_img, hour_img, wday_img, mday_img, mon_img, year_img},
          56'h00_00_00_01_01_01_00);
      chk("R1 busy/done", {busy, upd_done}, 2'b00);
   endtask

   task automatic t_uip_timing();
      wr(3'd0, 8'h10);
      @(negedge clk);
      tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
      chk("R8 busy after tick", busy, 1'b1);
      for (int i = 0; i < UIP - 1; i++) @(negedge clk);
      chk("R8 last busy cycle", {busy, upd_done, sec_img}, {2'b10, 8'h10});
      @(negedge clk);
      chk("R8 window end", {busy, upd_done, sec_img}, {2'b01, 8'h11});
      @(negedge clk);
      chk("R8 done one cycle", upd_done, 1'b0);
   endtask

   task automatic t_wrap();
      logic b, u;
      set_date(8'h23, 8'h12, 8'h31, 8'h07, 8'h23, 8'h59, 8'h59);
      tick_wait(b, u);
      chk("R3 hms wrap", {hour_img, min_img, sec_img}, 24'h00_00_00);
      chk("R3 weekday wrap", wday_img, 8'h01);
      chk("R4 year end", {year_img, mon_img, mday_img}, 24'h24_01_01);
      set_date(8'h99, 8'h12, 8'h31, 8'h02, 8'h23, 8'h59, 8'h59);
      tick_wait(b, u);
      chk("R4 year 99 wrap", {year_img, mon_img, mday_img, wday_img}, 32'h00_01_01_03);
      set_date(8'h23, 8'h04, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
      tick_wait(b, u);
      chk("R4 30-day month", {mon_img, mday_img}, 16'h05_01);
      set_date(8'h23, 8'h07, 8'h30, 8'h05, 8'h23, 8'h59, 8'h59);
      tick_wait(b, u);
      chk("R4 31-day month", {mon_img, mday_img}, 16'h07_31);
   endtask

   task automatic t_leap();
      logic b, u;
      set_date(8'h24, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_wait(b, u);
      chk("R5 2024 feb 29", {mon_img, mday_img}, 16'h02_29);
      set_date(8'h24, 8'h02, 8'h29, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_wait(b, u);
      chk("R5 2024 mar 1", {mon_img, mday_img}, 16'h03_01);
      set_date(8'h23, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_wait(b, u);
      chk("R5 2023 no leap", {mon_img, mday_img}, 16'h03_01);
      set_date(8'h00, 8'h02, 8'h28, 8'h01, 8'h23, 8'h59, 8'h59);
      tick_wait(b, u);
      chk("R5 2000 leap", {mon_img, mday_img}, 16'h02_29);
   endtask

   task automatic t_binary();
      logic b, u;
      bin_mode = 1'b1;
      set_date(8'd23, 8'd12, 8'd31, 8'd3, 8'd23, 8'd59, 8'd58);
      tick_wait(b, u);
      chk("R6 binary seconds", sec_img, 8'd59);
      tick_wait(b, u);
      chk("R6 binary rollover", {year_img, mon_img, mday_img, wday_img, hour_img, min_img, sec_img},
          {8'd24, 8'd1, 8'd1, 8'd4, 8'd0, 8'd0, 8'd0});
      bin_mode = 1'b0;
   endtask

   task automatic t_12h();
      logic b, u;
      hr24 = 1'b0;
      set_date(8'h23, 8'h06, 8'h15, 8'h02, 8'h91, 8'h59, 8'h59);
      tick_wait(b, u);
      chk("R7 11PM to 12AM", {hour_img, mday_img, wday_img}, 24'h12_16_03);
      wr(3'd2, 8'h11); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
      tick_wait(b, u);
      chk("R7 11AM to 12PM", hour_img, 8'h92);
      wr(3'd2, 8'h12); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
      tick_wait(b, u);
      chk("R7 12AM load to 1AM", hour_img, 8'h01);
      wr(3'd2, 8'h92); wr(3'd1, 8'h59); wr(3'd0, 8'h59);
      tick_wait(b, u);
      chk("R7 12PM load to 1PM", hour_img, 8'h81);
      hr24 = 1'b1;
   endtask

   task automatic t_halt();
      logic b, u;
      wr(3'd0, 8'h10);
      osc_ctl = 3'b000;
      tick_wait(b, u);
      chk("R2 halted 000", {b, u, sec_img}, {2'b00, 8'h10});
      osc_ctl = 3'b110;
      tick_wait(b, u);
      chk("R2 halted 110", {b, u, sec_img}, {2'b00, 8'h10});
      osc_ctl = 3'b010;
      tick_wait(b, u);
      chk("R2 running 010", {b, u, sec_img}, {2'b11, 8'h11});
   endtask

   task automatic t_set();
      logic b, u;
      wr(3'd0, 8'h20);
      @(negedge clk);
      set_hold = 1'b1;
      tick_wait(b, u);
      chk("R9 held update", {b, u, sec_img}, {2'b01, 8'h20});
      wr(3'd0, 8'h40);
      chk("R9 write visible in hold", sec_img, 8'h40);
      tick_wait(b, u);
      chk("R10 write not loaded in hold", sec_img, 8'h40);
      @(negedge clk);
      set_hold = 1'b0;
      @(negedge clk);
      tick_wait(b, u);
      chk("R10 loaded on release", sec_img, 8'h41);
   endtask

   task automatic t_ignore();
      logic b, u;
      logic [55:0] snap;
      snap = {sec_img, min_img, hour_img, wday_img, mday_img, mon_img, year_img};
      wr(3'd7, 8'h55);
      chk("R10 select 7 ignored", {sec_img, min_img, hour_img, wday_img, mday_img, mon_img, year_img}, snap);
      tick_wait(b, u);
      chk("R10 select 7 no time load", sec_img, 8'h42);
   endtask

   task automatic t_same_cycle();
      logic b, u;
      set_date(8'h23, 8'h03, 8'h10, 8'h04, 8'h03, 8'h05, 8'h10);
      @(negedge clk);
      tick_1hz = 1'b1; wr_en = 1'b1; wr_sel = 3'd1; wr_data = 8'h20;
      @(negedge clk);
      tick_1hz = 1'b0; wr_en = 1'b0;
      for (int i = 0; i < UIP + 1; i++) @(negedge clk);
      chk("R11 write+tick", {min_img, sec_img}, 16'h20_11);
      @(negedge clk);
      set_hold = 1'b1;
      wr(3'd0, 8'h30); wr(3'd1, 8'h07);
      @(negedge clk);
      set_hold = 1'b0; tick_1hz = 1'b1;
      @(negedge clk);
      tick_1hz = 1'b0;
      for (int i = 0; i < UIP + 1; i++) @(negedge clk);
      chk("R11 release+tick", {min_img, sec_img}, 16'h07_31);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_uip_timing();
      t_wrap();
      t_leap();
      t_binary();
      t_12h();
      t_halt();
      t_set();
      t_ignore();
      t_same_cycle();
      done = 1;
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      repeat (50000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual hung expected finished");
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   end

endmodule